// File: doc/BRIEF.md
# Clockless Level-Latching Interrupt Capture

This block captures wake-up and power-down events on eight input lines. Each line has its own sticky status bit, held in a flop with an asynchronous set. The bit sets as soon as the line sits at its active level, so capture still works while the bus clock is gated off. Software selects the active level of each line, enables lines onto a single interrupt output, and releases status bits by writing ones to a clear register.

The status flops feed the interrupt output straight through an enable AND and an OR reduction. A sleeping system can therefore wake on a captured event before any clock runs. Status reads on the register bus go through a two-flop synchroniser, because the flops change state with no relation to the bus clock. Capture is level-only: there is no edge detection and no readback of the live pin value.

The register port is a simple single-cycle request interface. A write takes effect on the clock edge where it is sampled. Read data appears the cycle after the request.

Top module: `latch_irq_capture`

## Requirements
- R1: After an asynchronous reset, enable, polarity and mode read as zero, all status bits are clear, `irq_o` is low and `rdata_o` is zero.
- R2: Polarity register (offset 0x10) bit n set to 0 makes line n active-high, and set to 1 makes it active-low. While line n is at its active level, status bit n sets at once, with no clock edge needed.
- R3: A set status bit stays set until a bus write to the clear register (offset 0x0C) has a 1 in bit n. Zero bits in that write leave status unchanged. The clear register reads as zero.
- R4: If line n is still at its active level when its clear write is sampled, status bit n stays set.
- R5: The raw status register (offset 0x04, bits 7:0) passes through a two-flop synchroniser. A bit latched between two rising edges first shows in a read request sampled on the third rising edge after it latched.
- R6: The masked status register (offset 0x08, bits 7:0) reads as synchronised raw status AND enable. Bits 31:8 read as zero.
- R7: `irq_o` is the OR over all lines of status AND enable (offset 0x00). It follows the status flops without any clock edge, including while the clock is stopped.
- R8: Enable (0x00), polarity (0x10) and mode (0x14) store write data bits 7:0 and read them back, with upper bits reading zero. The mode value has no effect on capture.
- R9: `rdata_o` carries the addressed register in the cycle after a read request and is zero otherwise. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock (may be stopped) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 8 | Event input lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check several properties. A status bit falls only where a clear write was sampled. An active line is always reflected in its status bit. The synchronised status lags the flops by exactly two edges. The interrupt never rises with all enables off, and read data is zero when no read was issued. Other behaviours need the bench's scenarios and its cycle model: capture while the clock is stopped, re-latching when clearing a still-active line, the active-low encoding, register readback width, and silence at unmapped offsets.

// File: rtl/latch_irq_capture_pkg.sv
package latch_irq_capture_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_POL    = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 5'h14;
endpackage

// File: rtl/lic_cell.sv
// Sticky status flop: asynchronous set from the active level, synchronous clear.
module lic_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge act_i) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (act_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import latch_irq_capture_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] raw_sync_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic [NUM_CH-1:0] clr_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_CH;

  logic              wr_en, rd_en;
  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] wbits;
  logic [NUM_CH-1:0] rd_mux;
  logic              unused_wdata;

  assign wr_en        = req_i & we_i;
  assign rd_en        = req_i & ~we_i;
  assign wbits        = wdata_i[NUM_CH-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CH];

  // Clear acts on the edge that samples the write.
  assign clr_o = (wr_en && addr_i == OFF_CLEAR) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pol_o  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      unique case (addr_i)
        OFF_ENABLE: en_o   <= wbits;
        OFF_POL:    pol_o  <= wbits;
        OFF_MODE:   mode_q <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_ENABLE: rd_mux = en_o;
      OFF_RAW:    rd_mux = raw_sync_i;
      OFF_MASKED: rd_mux = raw_sync_i & en_o;
      OFF_POL:    rd_mux = pol_o;
      OFF_MODE:   rd_mux = mode_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= {{PAD_W{1'b0}}, rd_mux};
    else            rdata_o <= '0;
  end
endmodule

// File: rtl/latch_irq_capture.sv
module latch_irq_capture
  import latch_irq_capture_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] line_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] act_vec;
  logic [NUM_CH-1:0] lat_q;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] raw_sync;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] pol_q;

  // Polarity 0 = active-high, 1 = active-low.
  assign act_vec = line_i ^ pol_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
    lic_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (act_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (lat_q[g])
    );
  end

  lic_sync #(.W(NUM_CH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lat_q),
    .q_o   (raw_sync)
  );

  lic_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .raw_sync_i(raw_sync),
    .rdata_o   (rdata_o),
    .en_o      (en_q),
    .pol_o     (pol_q),
    .clr_o     (clr_vec)
  );

  // Unclocked path so a stopped clock still sees the wake-up.
  assign irq_o = |(lat_q & en_q);
endmodule

// File: rtl/latch_irq_capture_chk.sv
module latch_irq_capture_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [NUM_CH-1:0] act_vec,
  input logic [NUM_CH-1:0] lat_q,
  input logic [NUM_CH-1:0] clr_vec,
  input logic [NUM_CH-1:0] raw_sync,
  input logic [NUM_CH-1:0] en_q,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o
);
  AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(lat_q) & ~lat_q & ~$past(clr_vec)) == '0)); // R3

  AST_ACTIVE_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((act_vec & ~lat_q) == '0)); // R2

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_sync == $past(lat_q, 2)); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0)); // R7

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> (rdata_o == '0)); // R9
endmodule

bind latch_irq_capture latch_irq_capture_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(latch_irq_capture_pkg::DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .act_vec (act_vec),
  .lat_q   (lat_q),
  .clr_vec (clr_vec),
  .raw_sync(raw_sync),
  .en_q    (en_q),
  .rdata_o (rdata_o),
  .irq_o   (irq_o)
);

// File: tb/latch_irq_capture_tb.sv
`timescale 1ns/1ps
module latch_irq_capture_tb;
  localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08,
                         A_CLR = 5'h0C, A_POL = 5'h10, A_MODE = 5'h14;

  logic        clk = 1'b0;
  logic        clk_en = 1'b1;
  logic        rst_n = 1'b0;
  logic [7:0]  line = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;
  string tag = "R1";

  // Reference model state
  logic [7:0]  m_lat = '0, m_s1 = '0, m_s2 = '0, m_en = '0, m_pol = '0, m_mode = '0;
  logic [31:0] m_rd = '0;

  latch_irq_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always begin
    #2.5;
    if (clk_en) clk = ~clk;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = '0; m_s1 = '0; m_s2 = '0; m_en = '0; m_pol = '0; m_mode = '0; m_rd = '0;
    end else begin
      logic [7:0] clr;
      m_rd = '0;
      if (req && !we) begin
        case (addr)
          A_EN:   m_rd = {24'h0, m_en};
          A_RAW:  m_rd = {24'h0, m_s2};
          A_MSK:  m_rd = {24'h0, m_s2 & m_en};
          A_POL:  m_rd = {24'h0, m_pol};
          A_MODE: m_rd = {24'h0, m_mode};
          default: m_rd = '0;
        endcase
      end
      clr = (req && we && addr == A_CLR) ? wdata[7:0] : 8'h00;
      m_s2 = m_s1;
      m_s1 = m_lat;
      m_lat = (m_lat & ~clr) | (line ^ m_pol);
      if (req && we) begin
        case (addr)
          A_EN:   m_en = wdata[7:0];
          A_POL:  m_pol = wdata[7:0];
          A_MODE: m_mode = wdata[7:0];
          default: ;
        endcase
      end
      m_lat = m_lat | (line ^ m_pol);
    end
  end

  task automatic chk(input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(irq == |(m_lat & m_en), {31'h0, irq}, {31'h0, |(m_lat & m_en)});
    chk(rdata == m_rd, rdata, m_rd);
  endtask

  task automatic step(input logic [7:0] p, input logic rq, input logic w,
                      input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    line = p; req = rq; we = w; addr = a; wdata = d;
    #1;
    m_lat = m_lat | (line ^ m_pol);
    chk(irq == |(m_lat & m_en), {31'h0, irq}, {31'h0, |(m_lat & m_en)});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(line, 1'b1, 1'b1, a, d);
  endtask
  task automatic rd(input logic [4:0] a);
    step(line, 1'b1, 1'b0, a, '0);
  endtask
  task automatic setl(input logic [7:0] p);
    step(p, 1'b0, 1'b0, '0, '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(line, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(irq == 1'b0, {31'h0, irq}, 32'h0);
    chk(rdata == 32'h0, rdata, 32'h0);
    rst_n = 1'b1;
    tag = "R1";
    rd(A_EN); rd(A_RAW); rd(A_MSK); rd(A_CLR); rd(A_POL); rd(A_MODE); idle(1);

    tag = "R8";
    wr(A_EN, 32'hFFFF_FFA5); wr(A_MODE, 32'h0000_013C);
    rd(A_EN); rd(A_MODE); rd(A_POL); idle(1);

    tag = "R2";  // active-high pulse on line 0
    setl(8'h01); setl(8'h00); idle(3); rd(A_RAW); idle(1);
    tag = "R2";  // active-low on line 1
    setl(8'h02); wr(A_POL, 32'h02); setl(8'h00); setl(8'h02); idle(3);
    rd(A_RAW);
    tag = "R6";
    rd(A_MSK); idle(1);

    tag = "R3";
    wr(A_CLR, 32'h0); idle(3); rd(A_RAW);
    wr(A_CLR, 32'h01); idle(3); rd(A_RAW); rd(A_CLR); idle(1);

    tag = "R4";
    setl(8'h06); wr(A_CLR, 32'h04); idle(3); rd(A_RAW);
    setl(8'h02); wr(A_CLR, 32'h06); idle(3); rd(A_RAW); idle(1);

    tag = "R5";
    setl(8'h12); setl(8'h02);
    rd(A_RAW); rd(A_RAW); rd(A_RAW); rd(A_RAW); idle(1);
    wr(A_CLR, 32'h10); idle(3);

    tag = "R7";  // clock stopped: capture and interrupt still work
    @(negedge clk);
    compare();
    clk_en = 1'b0;
    #7;
    line = 8'h22;
    #1;
    m_lat = m_lat | (line ^ m_pol);
    chk(irq == 1'b1, {31'h0, irq}, 32'h1);
    line = 8'h02;
    #4;
    chk(irq == 1'b1, {31'h0, irq}, 32'h1);
    clk_en = 1'b1;
    idle(3); rd(A_MSK); wr(A_CLR, 32'h20); idle(3); rd(A_MSK); idle(1);

    tag = "R8";  // mode has no effect
    wr(A_MODE, 32'hFF); setl(8'h82); setl(8'h02); idle(3); rd(A_RAW); rd(A_MODE);
    wr(A_CLR, 32'h80); idle(3);

    tag = "R9";
    rd(5'h18); wr(5'h1C, 32'hFF); wr(5'h01, 32'h00); rd(A_EN); rd(5'h01); idle(2);

    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule